// File: doc/BRIEF.md
# Receive Queue with Per-Byte Error Tags

This block buffers characters coming out of a serial deserializer until the host collects them. Each slot holds an 8-bit data byte and three error tags that the deserializer reported for that byte. The tags are stored with the byte. They reach the host only when their own byte becomes the oldest entry, so the status the host sees always belongs to the byte it is about to take.

The oldest entry is shown on a read-only holding output. A one-cycle host read strobe removes it and exposes the next one. There are two interrupt sources, and both pass through a single enable bit:

- **Data-ready interrupt.** With queueing on, it follows the fill level against a selectable trigger. With queueing off, the block acts as a single holding register and the interrupt fires on every character.
- **Time-out interrupt.** It reports data that sits below the trigger while the line has gone quiet, so no data is stranded.

Top module: `rx_tagged_queue`

## Requirements
- R1: Each entry stores 8 data bits and 3 tag bits. `head_data` and `head_tags` show the oldest stored entry and read zero while the queue is empty.
- R2: A `rd_en` pulse while data is held removes the head entry. The next entry's byte and tags appear on the head outputs right after that clock edge. `rd_en` while empty changes nothing.
- R3: `level` equals the number of held entries and never exceeds 16. A write and a read in the same cycle leave `level` unchanged.
- R4: A write is dropped when the queue is at capacity and no read happens in the same cycle.
  - A dropped write sets `overrun`.
  - `overrun` clears on the next read that removes an entry.
- R5: With `fifo_ctl[0]`=1, `rx_irq` is high while `level` is at or above the trigger chosen by `fifo_ctl[2:1]`: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 14.
- R6: With `fifo_ctl[0]`=0, capacity is one entry and `rx_irq` is high whenever an entry is held.
- R7: While data is held and no write or read occurs, `timeout_irq` rises after (4·(5+`word_len`)+12)·16 `tick16` pulses, counted from the last write, read or transition out of empty.
- R8: The time-out count advances only on cycles with `tick16` high. Any `wr_en` or removing read restarts it from zero.
- R9: `timeout_irq` drops when the queue empties or a new character is written.
- R10: `rx_irq` and `timeout_irq` are both held low while `irq_en` (the enable bit 0) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Sixteen-times bit-rate enable |
| wr_en | input | 1 | Received character strobe from the deserializer |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | Error tags for the received byte |
| rd_en | input | 1 | Host read of the holding output |
| fifo_ctl | input | 3 | Bit 0 enables queueing; bits 2:1 select the trigger |
| irq_en | input | 1 | Receive interrupt enable (bit 0) |
| word_len | input | 2 | Character length code, 5 plus value bits |
| head_data | output | 8 | Oldest held byte |
| head_tags | output | 3 | Error tags of the oldest held byte |
| level | output | 5 | Number of held entries |
| overrun | output | 1 | A character was dropped while full |
| rx_irq | output | 1 | Data-ready interrupt |
| timeout_irq | output | 1 | Receive time-out interrupt |

## Verification
A broken read pointer or entry count shows at the head outputs and on `level` at the first sample after the faulty edge. The bench compares every cycle against a reference queue, so the error is caught within one cycle. Tags that are misaligned with their bytes are caught the same way, because every write carries random tags.

A timer that counts wrongly or fails to restart shows only as a `timeout_irq` edge in the wrong cycle. The directed tests therefore check both sides of the boundary for two word lengths, plus a stretch with `tick16` held low.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int BYTE_W = 8;
   localparam int TAG_W  = 3;

   typedef struct packed {
      logic [TAG_W-1:0]  tags;
      logic [BYTE_W-1:0] data;
   } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  rxq_entry_t    wr_entry,
   input  logic          rd_en,
   input  logic          cap_one,
   output rxq_entry_t    head,
   output logic [CW-1:0] count,
   output logic          overrun,
   output logic          rd_ok
);
   rxq_entry_t    slots [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cap;
   logic          wr_ok;

   assign cap   = cap_one ? CW'(1) : CW'(DEPTH);
   assign rd_ok = rd_en && (count != '0);
   assign wr_ok = wr_en && ((count < cap) || rd_ok);
   assign head  = (count != '0) ? slots[rptr] : '0;

   always_ff @(posedge clk) begin
      if (wr_ok) slots[wptr] <= wr_entry;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
         if (rd_ok) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
         count <= count + CW'(wr_ok) - CW'(rd_ok);
         if (wr_en && !wr_ok) overrun <= 1'b1;
         else if (rd_ok)      overrun <= 1'b0;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R3
   AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ok) |=> (count == $past(count) && overrun)); // R4
   AST_READ_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok && !wr_en) |=> (count == $past(count) - CW'(1))); // R2
   AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && count == '0 && !wr_en) |=> (count == '0)); // R2
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
   parameter int TICKS_PER_BIT = 16,
   parameter int CHAR_MAX_BITS = 8,
   localparam int MAX_LIMIT = (4 * CHAR_MAX_BITS + 12) * TICKS_PER_BIT,
   localparam int TW = $clog2(MAX_LIMIT + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       restart,
   input  logic       empty,
   input  logic [1:0] word_len,
   output logic       expired
);
   logic [TW-1:0] ticks, limit;

   always_comb
      limit = TW'((4 * (CHAR_MAX_BITS - 3 + int'(word_len)) + 12) * TICKS_PER_BIT);

   always_ff @(posedge clk) begin
      if (!rst_n)                      ticks <= '0;
      else if (restart || empty)       ticks <= '0;
      else if (tick && ticks < limit)  ticks <= ticks + TW'(1);
   end

   assign expired = !empty && (ticks >= limit);

   AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !expired); // R8
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart && !empty) |=> $stable(ticks)); // R8
endmodule

// File: rtl/rx_tagged_queue.sv
module rx_tagged_queue
   import rxq_pkg::*;
#(
   parameter int DEPTH         = 16,
   parameter int TICKS_PER_BIT = 16,
   parameter int TRIG_SEL0     = 1,
   parameter int TRIG_SEL1     = 4,
   parameter int TRIG_SEL2     = 8,
   parameter int TRIG_SEL3     = 14,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [TAG_W-1:0]  wr_tags,
   input  logic              rd_en,
   input  logic [2:0]        fifo_ctl,
   input  logic              irq_en,
   input  logic [1:0]        word_len,
   output logic [BYTE_W-1:0] head_data,
   output logic [TAG_W-1:0]  head_tags,
   output logic [CW-1:0]     level,
   output logic              overrun,
   output logic              rx_irq,
   output logic              timeout_irq
);
   generate
      if (DEPTH < 2)                     $error("DEPTH must be at least 2");
      if (TRIG_SEL3 > DEPTH)             $error("trigger exceeds DEPTH");
      if (TRIG_SEL0 < 1)                 $error("trigger must be at least 1");
      if (TICKS_PER_BIT < 1)             $error("TICKS_PER_BIT must be positive");
   endgenerate

   rxq_entry_t    in_e, head_e;
   logic          rd_ok, expired;
   logic [CW-1:0] thresh;

   assign in_e = '{tags: wr_tags, data: wr_data};

   rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(in_e),
      .rd_en(rd_en), .cap_one(!fifo_ctl[0]), .head(head_e),
      .count(level), .overrun(overrun), .rd_ok(rd_ok)
   );

   rxq_timer #(.TICKS_PER_BIT(TICKS_PER_BIT), .CHAR_MAX_BITS(BYTE_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .restart(wr_en || rd_ok),
      .empty(level == '0), .word_len(word_len), .expired(expired)
   );

   always_comb begin
      if (!fifo_ctl[0]) thresh = CW'(1);
      else begin
         unique case (fifo_ctl[2:1])
            2'd0:    thresh = CW'(TRIG_SEL0);
            2'd1:    thresh = CW'(TRIG_SEL1);
            2'd2:    thresh = CW'(TRIG_SEL2);
            default: thresh = CW'(TRIG_SEL3);
         endcase
      end
   end

   assign head_data   = head_e.data;
   assign head_tags   = head_e.tags;
   assign rx_irq      = irq_en && (level >= thresh);
   assign timeout_irq = irq_en && expired;

   AST_RX_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (level != '0)); // R5
   AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_irq |-> (level != '0)); // R7
   AST_TIMEOUT_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !timeout_irq); // R9
   AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_ctl[0] && $past(!fifo_ctl[0]) && $past(level) <= CW'(1)) |-> (level <= CW'(1))); // R6
endmodule

// File: tb/rx_tagged_queue_test.sv
module rx_tagged_queue_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic tick16 = 1'b0, wr_en = 1'b0, rd_en = 1'b0, irq_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] wr_tags = '0, fifo_ctl = '0;
   logic [1:0] word_len = '0;
   logic [7:0] head_data;
   logic [2:0] head_tags;
   logic [4:0] level;
   logic overrun, rx_irq, timeout_irq;

   int total = 0, bad = 0;
   logic [10:0] q[$];
   bit m_ov = 0;
   int m_t = 0;

   always #2 clk = ~clk;

   rx_tagged_queue uut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
      .wr_tags(wr_tags), .rd_en(rd_en), .fifo_ctl(fifo_ctl), .irq_en(irq_en),
      .word_len(word_len), .head_data(head_data), .head_tags(head_tags),
      .level(level), .overrun(overrun), .rx_irq(rx_irq), .timeout_irq(timeout_irq)
   );

   function automatic int lim(input logic [1:0] wl);
      return (4 * (5 + int'(wl)) + 12) * 16;
   endfunction

   function automatic int trig(input logic [2:0] fc);
      if (!fc[0]) return 1;
      case (fc[2:1])
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      logic [10:0] h;
      h = (q.size() > 0) ? q[0] : 11'd0;
      chk("R1 head_data", int'(head_data), int'(h[7:0]));
      chk("R1 head_tags", int'(head_tags), int'(h[10:8]));
      chk("R3 level", int'(level), q.size());
      chk("R4 overrun", int'(overrun), int'(m_ov));
      chk("R5 R6 R10 rx_irq", int'(rx_irq), int'(irq_en && q.size() >= trig(fifo_ctl)));
      chk("R7 R9 R10 timeout_irq", int'(timeout_irq),
          int'(irq_en && q.size() > 0 && m_t >= lim(word_len)));
   endtask

   task automatic step(input bit w, input bit r);
      bit rok, wok, was_empty;
      int cap;
      @(negedge clk);
      wr_en   = w;
      rd_en   = r;
      wr_data = 8'($urandom);
      wr_tags = 3'($urandom);
      @(posedge clk);
      cap = fifo_ctl[0] ? 16 : 1;
      was_empty = (q.size() == 0);
      rok = r && q.size() > 0;
      wok = w && (q.size() < cap || rok);
      if (w || rok || was_empty) m_t = 0;
      else if (tick16 && m_t < lim(word_len)) m_t++;
      if (rok) begin void'(q.pop_front()); m_ov = 0; end
      if (wok) q.push_back({wr_tags, wr_data});
      else if (w) m_ov = 1;
      #1;
      check_all();
   endtask

   initial begin
      #(4 * 200000);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      check_all(); // R1 reset state
      @(negedge clk); rst_n = 1'b1;
      fifo_ctl = 3'b001; irq_en = 1'b1; tick16 = 1'b1;

      // R1 R2: empty read ignored, then order and tags
      step(0, 1);
      for (int i = 0; i < 5; i++) step(1, 0);
      for (int i = 0; i < 5; i++) step(0, 1);

      // R4: fill past capacity, then read clears overrun
      for (int i = 0; i < 18; i++) step(1, 0);
      chk("R4 full level", int'(level), 16);
      chk("R4 overrun set", int'(overrun), 1);
      step(1, 1); // R3 simultaneous read and write at full
      chk("R3 level kept", int'(level), 16);
      step(0, 1);
      chk("R4 overrun cleared", int'(overrun), 0);
      while (q.size() > 0) step(0, 1);

      // R5: each trigger selection
      for (int s = 0; s < 4; s++) begin
         fifo_ctl = {2'(s), 1'b1};
         for (int i = 0; i < 15; i++) step(1, 0);
         while (q.size() > 0) step(0, 1);
      end

      // R7: time-out boundaries for two word lengths
      fifo_ctl = 3'b111;
      for (int k = 0; k < 2; k++) begin
         word_len = (k == 0) ? 2'd0 : 2'd3;
         step(1, 0);
         for (int i = 0; i < lim(word_len) - 1; i++) step(0, 0);
         chk("R7 not yet", int'(timeout_irq), 0);
         step(0, 0);
         chk("R7 fires", int'(timeout_irq), 1);
         step(1, 0);
         chk("R9 write clears", int'(timeout_irq), 0);
         for (int i = 0; i < lim(word_len); i++) step(0, 0);
         step(0, 1);
         chk("R8 read restarts", int'(timeout_irq), 0);
         step(0, 1);
         chk("R9 empty", int'(level), 0);
      end

      // R8: no ticks, no time-out
      word_len = 2'd0;
      step(1, 0);
      tick16 = 1'b0;
      for (int i = 0; i < 600; i++) step(0, 0);
      chk("R8 no tick no timeout", int'(timeout_irq), 0);
      tick16 = 1'b1;

      // R10: gate
      irq_en = 1'b0;
      for (int i = 0; i < 520; i++) step(0, 0);
      chk("R10 rx gated", int'(rx_irq), 0);
      chk("R10 timeout gated", int'(timeout_irq), 0);
      irq_en = 1'b1;
      step(0, 1);

      // R6: single holding register mode
      fifo_ctl = 3'b000;
      step(1, 0);
      chk("R6 rx_irq one char", int'(rx_irq), 1);
      step(1, 0);
      chk("R6 second dropped", int'(level), 1);
      chk("R6 overrun", int'(overrun), 1);
      step(0, 1);

      // random mix
      for (int i = 0; i < 6000; i++) begin
         if (i % 500 == 0) begin
            fifo_ctl = 3'($urandom);
            word_len = 2'($urandom);
            irq_en   = ($urandom % 8) != 0;
         end
         tick16 = ($urandom % 4) != 0;
         step(($urandom % 3) == 0, ($urandom % 4) == 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule